// File: doc/BRIEF.md
# Power-of-Two Clock Divider Bank

This block derives a set of slower clocks from one reference clock. Each channel divides the reference by a power of two between 1 and 64. A 3-bit factor field selects the ratio, and a separate enable bit lets the channel drive its output. The channels are identical. Each has its own pair of control registers, reached through a plain single-cycle write strobe and a combinational read path. The channels sit in the address space at a fixed stride of 0x100.

The output is gated without glitches. A channel starts only from the low phase of its divided clock and stops only at the end of a full period, so the output never carries a partial pulse and rests low. The factor register may be rewritten at any time. A new value takes effect only when the channel is next switched on, so the intended sequence is: disable, write the factor, enable. Starting and stopping are bounded in reference cycles by amounts that grow with the ratio.

Top module: `pow2div_bank`

## Requirements
- R1: After reset every channel reads factor 0 and enable 0, and every divided output is low with no edges.
- R2: At offset 0x43 from a channel's base, bits [2:0] hold the factor and the other bits read 0. At offset 0x46, bit 7 holds the enable and the other bits read 0. Any other offset reads 0. A write to offset 0x43 or 0x46 stores the matching bits.
- R3: Channel i occupies base i × 0x100. A write to one channel leaves the registers and the output of every other channel unchanged.
- R4: With factor f the output period is 2^(f−1) reference cycles. Factors 0 and 1 both give a period of 1, and factor 7 gives 64.
- R5: For ratios of 2 and above, the output is high for exactly half of each period.
- R6: Once the enable is written to 1, the output's first high phase begins within 2 + 3 × ratio reference cycles.
- R7: Once the enable is written to 0, the output is low within 3 × ratio reference cycles and stays low.
- R8: When a channel starts, its output begins in the low phase, and the first high pulse has the full length of half a period.
- R9: A factor written while the channel is running reads back at once, but the running ratio is unchanged until the channel is next enabled. The new ratio applies from then on.
- R10: At ratio 1 the output is the reference clock passed through the gate: high during every high phase of the reference while the channel is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Register address, channel base plus offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, 0 if unmapped |
| div_clk | output | NUM_DIV | Divided clock outputs, one per channel |

## Verification
Two events can fall in the same reference cycle. One is a register write that clears the enable. The other is the period boundary at which the divider decides whether to keep running. A disable that lands on the boundary must stop the channel at once, and one that lands just after it must wait a whole period. The bench provokes both cases by switching channels off at times set by the measured start latency and by randomly chosen ratios. It judges the result by requiring the output to have no edges and no high samples from 3 × ratio cycles on.

A second coincidence is a factor rewrite while the counter is running. The bench checks it by reading the register back and counting output edges before and after the next enable.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;

    localparam int FACT_W  = 3;
    localparam int DATA_W  = 8;
    localparam int SHIFT_W = 3;
    localparam int CNT_W   = (1 << FACT_W) - 2;
    localparam int STOP_W  = CNT_W + 2;
    localparam int EN_POS  = 7;

    localparam logic [7:0] DIV_OFS = 8'h43;
    localparam logic [7:0] EN_OFS  = 8'h46;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic [FACT_W-1:0] factor;
        logic              enable;
    } div_ctl_t;

    function automatic logic [SHIFT_W-1:0] factor_to_shift(input logic [FACT_W-1:0] f);
        if (f == '0)
            return '0;
        return SHIFT_W'(f - 1'b1);
    endfunction

    function automatic logic [CNT_W-1:0] period_mask(input logic [SHIFT_W-1:0] sh);
        logic [CNT_W:0] one_hot;
        one_hot = (CNT_W+1)'(1) << sh;
        return CNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/pow2div_regs.sv
module pow2div_regs
    import pow2div_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output div_ctl_t          ctl,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(BASE + int'(DIV_OFS));
    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(BASE + int'(EN_OFS));

    logic hit_div;
    logic hit_en;
    logic unused_wbits;

    assign hit_div      = (addr == DIV_ADDR);
    assign hit_en       = (addr == EN_ADDR);
    assign unused_wbits = ^wdata[EN_POS-1:FACT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en) begin
            if (hit_div)
                ctl.factor <= wdata[FACT_W-1:0];
            if (hit_en)
                ctl.enable <= wdata[EN_POS];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_div)
            rdata[FACT_W-1:0] = ctl.factor;
        else if (hit_en)
            rdata[EN_POS] = ctl.enable;
    end

    // R2
    factor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hit_div) |=> $stable(ctl.factor));

    // R2
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hit_en) |=> $stable(ctl.enable));

endmodule

// File: rtl/pow2div_core.sv
module pow2div_core
    import pow2div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_ctl_t ctl,
    output logic     div_clk
);

    gate_state_e        st;
    logic [SHIFT_W-1:0] shift_act;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   mask_act;
    logic               wrap;
    logic               gate_n;
    logic               slow_bit;
    logic [STOP_W-1:0]  stop_cnt;

    assign mask_act = period_mask(shift_act);
    assign wrap     = ((cnt & mask_act) == mask_act);

    // Enable is sampled only while idle or at a period boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= GATE_OFF;
            shift_act <= '0;
            cnt       <= '0;
        end else begin
            case (st)
                GATE_OFF: begin
                    if (ctl.enable) begin
                        st        <= GATE_ON;
                        shift_act <= factor_to_shift(ctl.factor);
                        cnt       <= '0;
                    end
                end
                GATE_ON: begin
                    if (wrap && !ctl.enable) begin
                        st  <= GATE_OFF;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= GATE_OFF;
            endcase
        end
    end

    // Gate for the pass-through path, moved only while clk is low
    always_ff @(negedge clk) begin
        if (rst)
            gate_n <= 1'b0;
        else
            gate_n <= (st == GATE_ON) && (shift_act == '0);
    end

    always_comb begin
        slow_bit = 1'b0;
        if (st == GATE_ON && shift_act != '0)
            slow_bit = cnt[shift_act - 1'b1];
    end

    assign div_clk = (shift_act == '0) ? (clk & gate_n) : slow_bit;

    always_ff @(posedge clk) begin
        if (rst)
            stop_cnt <= '0;
        else if (st == GATE_ON && !ctl.enable)
            stop_cnt <= stop_cnt + 1'b1;
        else
            stop_cnt <= '0;
    end

    // R6
    start_next_chk: assert property (@(posedge clk) disable iff (rst)
        (st == GATE_OFF && ctl.enable) |=> (st == GATE_ON && cnt == '0));

    // R8
    stop_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (st == GATE_ON && !wrap) |=> (st == GATE_ON));

    // R9
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == GATE_ON) |=> (st == GATE_OFF || $stable(shift_act)));

    // R7
    stop_window_chk: assert property (@(posedge clk) disable iff (rst)
        stop_cnt <= (STOP_W'(3) << shift_act));

endmodule

// File: rtl/pow2div_bank.sv
module pow2div_bank
    import pow2div_pkg::*;
#(
    parameter int NUM_DIV   = 3,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 0,
    parameter int STRIDE    = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_DIV-1:0] div_clk
);

    logic [DATA_W-1:0] rd_arr [NUM_DIV];

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_chan
        div_ctl_t ctl;

        pow2div_regs #(
            .ADDR_W (ADDR_W),
            .BASE   (BASE_ADDR + g * STRIDE)
        ) u_regs (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .addr  (addr),
            .wdata (wdata),
            .ctl   (ctl),
            .rdata (rd_arr[g])
        );

        pow2div_core u_core (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .div_clk (div_clk[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_DIV; i++)
            rdata = rdata | rd_arr[i];
    end

    // R3
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rd_arr[0] != '0, rd_arr[NUM_DIV-1] != '0}) <= 1 || NUM_DIV == 1);

endmodule

// File: tb/pow2div_bank_bench.sv
module pow2div_bank_bench;

    localparam int NUM    = 3;
    localparam int AW     = 12;
    localparam int STRIDE = 256;
    localparam logic [7:0] OFS_DIV = 8'h43;
    localparam logic [7:0] OFS_EN  = 8'h46;

    logic           clk = 1'b0;
    logic           rst;
    logic           wr_en;
    logic [AW-1:0]  addr;
    logic [7:0]     wdata;
    logic [7:0]     rdata;
    logic [NUM-1:0] dout;
    logic [1:0]     sel;
    logic           sel_out;
    int             rises;
    int             tests = 0;
    int             fails = 0;
    bit             done  = 1'b0;

    always #4 clk = ~clk;

    pow2div_bank #(.NUM_DIV(NUM), .ADDR_W(AW), .BASE_ADDR(0), .STRIDE(STRIDE)) u_pow2div_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .div_clk(dout)
    );

    assign sel_out = dout[sel];

    initial rises = 0;
    always @(posedge sel_out) rises = rises + 1;

    function automatic int ratio_of(input int f);
        return (f == 0) ? 1 : (1 << (f - 1));
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_le(input string req, input int act, input int lim);
        tests++;
        if (act > lim) begin
            fails++;
            $display("FAIL %s actual=%0d expected<=%0d", req, act, lim);
        end
    endtask

    task automatic wr(input int inst, input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        addr  = AW'(inst * STRIDE + int'(off));
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int inst, input logic [7:0] off, output int v);
        @(negedge clk);
        addr = AW'(inst * STRIDE + int'(off));
        #1;
        v = int'(rdata);
    endtask

    task automatic measure(input int n, output int r, output int h);
        int start;
        @(posedge clk);
        #2;
        start = rises;
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            if (sel_out) h++;
        end
        r = rises - start;
    endtask

    task automatic run_case(input int inst, input int f);
        int r, c, hl, n, er, eh;
        r   = ratio_of(f);
        sel = 2'(inst);
        wr(inst, OFS_EN, 8'h00);
        repeat (200) @(posedge clk);
        wr(inst, OFS_DIV, 8'(f));
        wr(inst, OFS_EN, 8'h80);
        c = 0;
        for (int i = 0; i < 500; i++) begin
            @(posedge clk);
            #2;
            c = c + 1;
            if (sel_out) break;
        end
        // Latency counted from the write edge; one wr() tail cycle already passed
        check_le("R6 enable latency", c + 1, 2 + 3 * r);
        if (r > 1) begin
            hl = 1;
            for (int i = 0; i < 100; i++) begin
                @(posedge clk);
                #2;
                if (!sel_out) break;
                hl++;
            end
            check_eq("R8 first pulse length", hl, r / 2);
        end
        n = (r == 1) ? 32 : 4 * r;
        measure(n, er, eh);
        check_eq("R4 edge count", er, n / r);
        if (r == 1) check_eq("R10 pass-through high samples", eh, n);
        else        check_eq("R5 high samples", eh, n / 2);
        wr(inst, OFS_EN, 8'h00);
        repeat (3 * r) @(posedge clk);
        measure(2 * r + 8, er, eh);
        check_eq("R7 edges after disable", er, 0);
        check_eq("R7 high after disable", eh, 0);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, er, eh, f, inst;
        void'($urandom(32'd4242));
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; sel = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < NUM; i++) begin
            rd(i, OFS_DIV, v); check_eq("R1 factor after reset", v, 0);
            rd(i, OFS_EN, v);  check_eq("R1 enable after reset", v, 0);
        end
        check_eq("R1 outputs low", int'(dout), 0);
        measure(20, er, eh);
        check_eq("R1 no edges", er, 0);

        // R2 field masking and unmapped read
        wr(0, OFS_DIV, 8'hFF); rd(0, OFS_DIV, v); check_eq("R2 factor field", v, 8'h07);
        wr(0, OFS_EN, 8'h7F);  rd(0, OFS_EN, v);  check_eq("R2 enable bit clear", v, 8'h00);
        wr(0, OFS_EN, 8'hFF);  rd(0, OFS_EN, v);  check_eq("R2 enable bit set", v, 8'h80);
        rd(0, 8'h44, v); check_eq("R2 unmapped offset", v, 0);
        wr(0, OFS_EN, 8'h00);
        wr(0, OFS_DIV, 8'h00);
        repeat (200) @(posedge clk);

        // R3 stride isolation
        wr(1, OFS_DIV, 8'h05);
        wr(1, OFS_EN, 8'h80);
        rd(1, OFS_DIV, v); check_eq("R3 target channel", v, 5);
        rd(0, OFS_DIV, v); check_eq("R3 channel 0 untouched", v, 0);
        rd(2, OFS_EN, v);  check_eq("R3 channel 2 untouched", v, 0);
        sel = 2'd0;
        measure(64, er, eh); check_eq("R3 channel 0 silent", er + eh, 0);
        sel = 2'd1;
        measure(64, er, eh); check_eq("R3 channel 1 runs", er, 4);
        wr(1, OFS_EN, 8'h00);

        // Every factor directed
        for (int k = 0; k < 8; k++) run_case(k % NUM, k);

        // R9 rewrite while running
        sel = 2'd0;
        wr(0, OFS_DIV, 8'h02);
        wr(0, OFS_EN, 8'h80);
        repeat (10) @(posedge clk);
        wr(0, OFS_DIV, 8'h07);
        rd(0, OFS_DIV, v); check_eq("R9 readback", v, 7);
        measure(64, er, eh); check_eq("R9 old ratio kept", er, 32);
        wr(0, OFS_EN, 8'h00);
        repeat (200) @(posedge clk);
        wr(0, OFS_EN, 8'h80);
        repeat (40) @(posedge clk);
        measure(256, er, eh); check_eq("R9 new ratio on re-enable", er, 4);
        wr(0, OFS_EN, 8'h00);

        // Random ratio and channel mix
        for (int k = 0; k < 8; k++) begin
            inst = int'($urandom % NUM);
            f    = int'($urandom % 8);
            run_case(inst, f);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule